// File: doc/BRIEF.md
# Key-Selected Configuration Data Port

This block lets firmware read a table of configuration entries one byte at a time through two registers. A 16-bit selector write chooses an entry and rewinds a byte offset. Each strobe on the byte-wide data port then either returns the next byte of that entry or, for entries marked as writable, stores the next byte into it. Entries live in two banks, a shared bank and an architecture-local bank, and each entry has its own length, loaded together with its bytes through a preload port while the bus side is quiet.

The selector key carries three fields. Bits [13:0] are the entry index. Bit 14 picks the architecture-local bank when set. Bit 15 opens the entry for writing. An index at or above `NUM_ENT` turns the selection into the reserved code 16'hFFFF, under which every access is dead. Multi-byte integers are preloaded least significant byte at offset 0, so they stream out little-endian. A write that fills an entry produces a one-cycle completion pulse naming the bank and index that was filled.

Top module: `cfgport`

## Requirements
- R1: After reset the selection is key 0 (shared bank, index 0, read-only) at offset 0, `data_rdata` is 0 and `done_pulse` is low.
- R2: A selector write always sets the offset to 0, whether or not the key is valid, so the next read returns byte 0 of the new entry.
- R3: A key whose bits [13:0] are not below `NUM_ENT` makes the selection invalid. Reads then return 0, and writes store nothing and raise no completion.
- R4: Key bit 14 set addresses the architecture-local bank and clear addresses the shared bank. The same index in the two banks names different entries.
- R5: A data read of a loaded entry with offset below its length returns the byte at the offset on `data_rdata` in the cycle after the strobe, then advances the offset by one. `data_rdata` holds its value until the next read.
- R6: A data read returns 0 and leaves the offset unchanged when the entry was never given a length, or when the offset is at or past the entry length.
- R7: A data write is accepted only when key bit 15 is set, the selection is valid and the offset is below the length. An accepted byte is stored at the offset and the offset advances. Any other write changes nothing.
- R8: When an accepted write makes the offset equal the length, `done_pulse` is high for exactly the next cycle, with `done_bank` and `done_index` naming the entry, and the offset returns to 0.
- R9: In a single cycle, a selector write takes precedence over any data access, and a data write takes precedence over a data read. The losing access has no effect.
- R10: Preload length and byte writes take effect only in cycles with no selector write, data read or data write. A preloaded length above `DEPTH` is stored as `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sel_wr | input | 1 | Selector register write strobe |
| sel_key | input | 16 | Key written to the selector |
| data_rd | input | 1 | Data port read strobe |
| data_wr | input | 1 | Data port write strobe |
| data_wdata | input | 8 | Byte written through the data port |
| data_rdata | output | 8 | Byte returned by the most recent read |
| done_pulse | output | 1 | One-cycle pulse when a writable entry has been filled |
| done_bank | output | 1 | Bank of the filled entry (1 = architecture-local) |
| done_index | output | IDX_W | Index of the filled entry |
| pl_len_we | input | 1 | Preload strobe for an entry length |
| pl_byte_we | input | 1 | Preload strobe for an entry byte |
| pl_bank | input | 1 | Preload bank |
| pl_index | input | IDX_W | Preload entry index |
| pl_offset | input | DW | Preload byte offset |
| pl_len | input | LEN_W | Preload length value |
| pl_byte | input | 8 | Preload byte value |

## Verification
Because the offset and the selected key can only be observed through the bytes they produce, a corrupted offset shows up on the next read strobe as a wrong byte, or as a zero where data was due. A key latched with the wrong bank or a wrong validity shows up on the first read after the select. A wrong write-acceptance decision shows up later, when the entry is read back, or at once as a missing or misplaced completion pulse. The bench compares `data_rdata` and the completion outputs against a behavioural model on every clock, so each such fault is reported in the cycle after the access that exposes it.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
    localparam int KEY_W       = 16;
    localparam int WR_BIT      = 15;
    localparam int BANK_BIT    = 14;
    localparam int IDX_FIELD_W = 14;

    typedef logic [KEY_W-1:0] key_t;

    localparam key_t INVALID_KEY = 16'hFFFF;
endpackage

// File: rtl/cfgport_keydec.sv
module cfgport_keydec
    import cfgport_pkg::*;
#(
    parameter int NUM_ENT = 8,
    parameter int IDX_W   = 3
) (
    input  key_t             key,
    output logic             valid,
    output logic             bank,
    output logic             wr_ok,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_FIELD_W-1:0] field;

    always_comb begin
        field = key[IDX_FIELD_W-1:0];
        valid = (key != INVALID_KEY) &&
                ({{(32-IDX_FIELD_W){1'b0}}, field} < 32'(NUM_ENT));
        bank  = key[BANK_BIT];
        wr_ok = valid && key[WR_BIT];
        idx   = field[IDX_W-1:0];
    end
endmodule

// File: rtl/cfgport_store.sv
module cfgport_store #(
    parameter int NUM_ENT = 8,
    parameter int DEPTH   = 16,
    parameter int LEN_W   = 16,
    parameter int IDX_W   = 3,
    parameter int DW      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             wbank,
    input  logic [IDX_W-1:0] widx,
    input  logic [DW-1:0]    woff,
    input  logic [7:0]       wdata,
    input  logic             lwe,
    input  logic             lbank,
    input  logic [IDX_W-1:0] lidx,
    input  logic [LEN_W-1:0] lval,
    input  logic             rbank,
    input  logic [IDX_W-1:0] ridx,
    input  logic [DW-1:0]    roff,
    output logic [7:0]       rbyte,
    output logic [LEN_W-1:0] rlen,
    output logic             rpres
);
    localparam int SLOT_W = 1 + IDX_W;
    localparam int SLOTS  = 1 << SLOT_W;
    localparam int AW     = SLOT_W + DW;
    localparam int CELLS  = 1 << AW;
    localparam logic [LEN_W-1:0] CAP = LEN_W'(DEPTH);

    logic [7:0]       mem   [CELLS];
    logic [LEN_W-1:0] len_d [SLOTS];
    logic [LEN_W-1:0] len_q [SLOTS];
    logic [SLOTS-1:0] pres_d, pres_q;
    logic [LEN_W-1:0] lval_c;
    logic [SLOT_W-1:0] lslot, rslot;

    always_comb begin
        lval_c = (lval > CAP) ? CAP : lval;
        lslot  = {lbank, lidx};
        rslot  = {rbank, ridx};
        pres_d = pres_q;
        for (int s = 0; s < SLOTS; s++) begin
            len_d[s] = len_q[s];
        end
        if (lwe) begin
            len_d[lslot]  = lval_c;
            pres_d[lslot] = 1'b1;
        end
        rbyte = mem[{rslot, roff}];
        rlen  = len_q[rslot];
        rpres = pres_q[rslot];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pres_q <= '0;
            for (int s = 0; s < SLOTS; s++) begin
                len_q[s] <= '0;
            end
        end else begin
            pres_q <= pres_d;
            for (int s = 0; s < SLOTS; s++) begin
                len_q[s] <= len_d[s];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[{wbank, widx, woff}] <= wdata;
        end
    end

    a_r10_len_capped: assert property (@(posedge clk) disable iff (!rst_n)
        lwe |=> (len_q[$past(lslot)] <= CAP))
        else $error("a_r10_len_capped");
endmodule

// File: rtl/cfgport_seq.sv
module cfgport_seq
    import cfgport_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_wr,
    input  key_t             sel_key,
    input  logic             sel_valid,
    input  logic             data_rd,
    input  logic             data_wr,
    input  logic [7:0]       wdata,
    input  logic             cur_valid,
    input  logic             cur_wr_ok,
    input  logic             cur_bank,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic [LEN_W-1:0] ent_len,
    input  logic             ent_pres,
    input  logic [7:0]       ent_byte,
    output key_t             key_q,
    output logic [LEN_W-1:0] off_q,
    output logic [7:0]       rdata,
    output logic             done,
    output logic             done_bank,
    output logic [IDX_W-1:0] done_idx,
    output logic             mem_we,
    output logic [7:0]       mem_wdata
);
    typedef struct packed {
        key_t             key;
        logic [LEN_W-1:0] off;
        logic [7:0]       rdata;
        logic             done;
        logic             dbank;
        logic [IDX_W-1:0] didx;
    } st_t;

    st_t st_d, st_q;
    logic [LEN_W-1:0] off_nxt;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = wdata;
        off_nxt   = st_q.off + LEN_W'(1);
        if (sel_wr) begin
            st_d.key = sel_valid ? sel_key : INVALID_KEY;
            st_d.off = '0;
        end else if (data_wr) begin
            if (cur_wr_ok && (st_q.off < ent_len)) begin
                mem_we = 1'b1;
                if (off_nxt == ent_len) begin
                    st_d.done  = 1'b1;
                    st_d.dbank = cur_bank;
                    st_d.didx  = cur_idx;
                    st_d.off   = '0;
                end else begin
                    st_d.off = off_nxt;
                end
            end
        end else if (data_rd) begin
            if (cur_valid && ent_pres && (st_q.off < ent_len)) begin
                st_d.rdata = ent_byte;
                st_d.off   = off_nxt;
            end else begin
                st_d.rdata = 8'h00;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign key_q     = st_q.key;
    assign off_q     = st_q.off;
    assign rdata     = st_q.rdata;
    assign done      = st_q.done;
    assign done_bank = st_q.dbank;
    assign done_idx  = st_q.didx;

    a_r2_select_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> (off_q == '0))
        else $error("a_r2_select_rewinds");

    a_r8_done_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (off_q == '0))
        else $error("a_r8_done_rewinds");

    a_r6_hold_past_end: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !sel_wr && !data_wr && (off_q >= ent_len)) |=> $stable(off_q))
        else $error("a_r6_hold_past_end");

    a_r3_no_store_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (cur_valid && (key_q != INVALID_KEY)))
        else $error("a_r3_no_store_invalid");
endmodule

// File: rtl/cfgport.sv
module cfgport
    import cfgport_pkg::*;
#(
    parameter int NUM_ENT = 8,
    parameter int DEPTH   = 16,
    parameter int LEN_W   = 16,
    parameter int IDX_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
    parameter int DW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_wr,
    input  logic [15:0]      sel_key,
    input  logic             data_rd,
    input  logic             data_wr,
    input  logic [7:0]       data_wdata,
    output logic [7:0]       data_rdata,
    output logic             done_pulse,
    output logic             done_bank,
    output logic [IDX_W-1:0] done_index,
    input  logic             pl_len_we,
    input  logic             pl_byte_we,
    input  logic             pl_bank,
    input  logic [IDX_W-1:0] pl_index,
    input  logic [DW-1:0]    pl_offset,
    input  logic [LEN_W-1:0] pl_len,
    input  logic [7:0]       pl_byte
);
    logic             bus_busy;
    logic             in_valid, in_bank, in_wr_ok;
    logic [IDX_W-1:0] in_idx;
    logic             cur_valid, cur_bank, cur_wr_ok;
    logic [IDX_W-1:0] cur_idx;
    key_t             key_q;
    logic [LEN_W-1:0] off_q;
    logic [LEN_W-1:0] ent_len;
    logic             ent_pres;
    logic [7:0]       ent_byte;
    logic             seq_we;
    logic [7:0]       seq_wdata;
    logic             st_we, st_wbank, st_lwe;
    logic [IDX_W-1:0] st_widx;
    logic [DW-1:0]    st_woff;
    logic [7:0]       st_wdata;

    assign bus_busy = sel_wr | data_rd | data_wr;

    cfgport_keydec #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_dec_in (
        .key(sel_key), .valid(in_valid), .bank(in_bank),
        .wr_ok(in_wr_ok), .idx(in_idx)
    );

    cfgport_keydec #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_dec_cur (
        .key(key_q), .valid(cur_valid), .bank(cur_bank),
        .wr_ok(cur_wr_ok), .idx(cur_idx)
    );

    cfgport_seq #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .sel_wr(sel_wr), .sel_key(sel_key), .sel_valid(in_valid),
        .data_rd(data_rd), .data_wr(data_wr), .wdata(data_wdata),
        .cur_valid(cur_valid), .cur_wr_ok(cur_wr_ok),
        .cur_bank(cur_bank), .cur_idx(cur_idx),
        .ent_len(ent_len), .ent_pres(ent_pres), .ent_byte(ent_byte),
        .key_q(key_q), .off_q(off_q), .rdata(data_rdata),
        .done(done_pulse), .done_bank(done_bank), .done_idx(done_index),
        .mem_we(seq_we), .mem_wdata(seq_wdata)
    );

    always_comb begin
        st_lwe = pl_len_we & ~bus_busy;
        if (seq_we) begin
            st_we    = 1'b1;
            st_wbank = cur_bank;
            st_widx  = cur_idx;
            st_woff  = off_q[DW-1:0];
            st_wdata = seq_wdata;
        end else begin
            st_we    = pl_byte_we & ~bus_busy;
            st_wbank = pl_bank;
            st_widx  = pl_index;
            st_woff  = pl_offset;
            st_wdata = pl_byte;
        end
    end

    cfgport_store #(
        .NUM_ENT(NUM_ENT), .DEPTH(DEPTH), .LEN_W(LEN_W),
        .IDX_W(IDX_W), .DW(DW)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(st_we), .wbank(st_wbank), .widx(st_widx),
        .woff(st_woff), .wdata(st_wdata),
        .lwe(st_lwe), .lbank(pl_bank), .lidx(pl_index), .lval(pl_len),
        .rbank(cur_bank), .ridx(cur_idx), .roff(off_q[DW-1:0]),
        .rbyte(ent_byte), .rlen(ent_len), .rpres(ent_pres)
    );

    a_r7_store_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && data_wr) |-> key_q[WR_BIT])
        else $error("a_r7_store_needs_flag");

    a_r8_done_one_entry: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> $past(seq_we))
        else $error("a_r8_done_one_entry");
endmodule

// File: tb/cfgport_test.sv
`timescale 1ns/1ps
module cfgport_test;
    localparam int IDX_W = 3;
    localparam int DW    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_wr = 0, data_rd = 0, data_wr = 0;
    logic [15:0] sel_key = '0;
    logic [7:0]  data_wdata = '0;
    logic [7:0]  data_rdata;
    logic        done_pulse, done_bank;
    logic [IDX_W-1:0] done_index;
    logic pl_len_we = 0, pl_byte_we = 0, pl_bank = 0;
    logic [IDX_W-1:0] pl_index = '0;
    logic [DW-1:0]    pl_offset = '0;
    logic [15:0]      pl_len = '0;
    logic [7:0]       pl_byte = '0;

    int checks = 0, fails = 0;
    bit finished = 0;

    logic [15:0] mkey;
    int          moff;
    int          mlen  [2][8];
    bit          mpres [2][8];
    logic [7:0]  mmem  [2][8][16];
    logic [7:0]  erdata;
    bit          edone;
    bit          ebank;
    int          eidx;

    always #2.5 clk = ~clk;

    cfgport uut (
        .clk(clk), .rst_n(rst_n),
        .sel_wr(sel_wr), .sel_key(sel_key),
        .data_rd(data_rd), .data_wr(data_wr),
        .data_wdata(data_wdata), .data_rdata(data_rdata),
        .done_pulse(done_pulse), .done_bank(done_bank), .done_index(done_index),
        .pl_len_we(pl_len_we), .pl_byte_we(pl_byte_we), .pl_bank(pl_bank),
        .pl_index(pl_index), .pl_offset(pl_offset), .pl_len(pl_len),
        .pl_byte(pl_byte)
    );

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic tick(input string tag);
        bit busy;
        int b, i;
        busy  = sel_wr | data_rd | data_wr;
        edone = 0;
        b = mkey[14];
        i = mkey[2:0];
        if (sel_wr) begin
            mkey = (sel_key[13:0] < 8) ? sel_key : 16'hFFFF;
            moff = 0;
        end else if (data_wr) begin
            if (mkey != 16'hFFFF && mkey[15] && moff < mlen[b][i]) begin
                mmem[b][i][moff] = data_wdata;
                moff++;
                if (moff == mlen[b][i]) begin
                    edone = 1; ebank = b[0]; eidx = i; moff = 0;
                end
            end
        end else if (data_rd) begin
            if (mkey != 16'hFFFF && mpres[b][i] && moff < mlen[b][i]) begin
                erdata = mmem[b][i][moff];
                moff++;
            end else begin
                erdata = 8'h00;
            end
        end
        if (!busy && pl_len_we) begin
            mlen[pl_bank][pl_index]  = (pl_len > 16) ? 16 : int'(pl_len);
            mpres[pl_bank][pl_index] = 1;
        end
        if (!busy && pl_byte_we) mmem[pl_bank][pl_index][pl_offset] = pl_byte;
        @(negedge clk);
        chk(tag, data_rdata, erdata, "data_rdata");
        chk(tag, done_pulse, edone, "done_pulse");
        if (edone) begin
            chk(tag, done_bank, ebank, "done_bank");
            chk(tag, done_index, eidx, "done_index");
        end
        sel_wr = 0; data_rd = 0; data_wr = 0; pl_len_we = 0; pl_byte_we = 0;
    endtask

    task automatic sel(input logic [15:0] k, input string tag);
        sel_wr = 1; sel_key = k; tick(tag);
    endtask
    task automatic rd(input string tag);
        data_rd = 1; tick(tag);
    endtask
    task automatic wr(input logic [7:0] d, input string tag);
        data_wr = 1; data_wdata = d; tick(tag);
    endtask
    task automatic pll(input bit b, input int i, input int l);
        pl_len_we = 1; pl_bank = b; pl_index = IDX_W'(i); pl_len = 16'(l); tick("R10");
    endtask
    task automatic plb(input bit b, input int i, input int o, input logic [7:0] d);
        pl_byte_we = 1; pl_bank = b; pl_index = IDX_W'(i);
        pl_offset = DW'(o); pl_byte = d; tick("R10");
    endtask

    initial begin
        mkey = 16'h0000; moff = 0; erdata = 8'h00; edone = 0; ebank = 0; eidx = 0;
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 8; i++) begin
                mlen[b][i] = 0; mpres[b][i] = 0;
                for (int o = 0; o < 16; o++) mmem[b][i][o] = 8'h00;
            end
        repeat (3) @(negedge clk);
        chk("R1", data_rdata, 0, "reset data_rdata");
        chk("R1", done_pulse, 0, "reset done_pulse");
        rst_n = 1'b1;
        @(negedge clk);

        // shared entry 0 holds a 32-bit value, least significant byte first
        pll(0, 0, 4);
        plb(0, 0, 0, 8'h11); plb(0, 0, 1, 8'h22); plb(0, 0, 2, 8'h33); plb(0, 0, 3, 8'h44);
        pll(1, 2, 3);
        plb(1, 2, 0, 8'hAA); plb(1, 2, 1, 8'hBB); plb(1, 2, 2, 8'hCC);
        pll(0, 3, 2);
        pll(1, 5, 20);
        for (int o = 0; o < 16; o++) plb(1, 5, o, 8'(o * 3 + 1));

        // R1: key 0 selected out of reset; R5 streaming; R6 past the end
        rd("R1"); rd("R5"); rd("R5"); rd("R5");
        rd("R6"); rd("R6");
        tick("R5");
        // R2 rewind
        sel(16'h0000, "R2"); rd("R2"); rd("R2");
        sel(16'h0000, "R2"); rd("R2");
        // R4 banks
        sel(16'h4002, "R4"); rd("R4"); rd("R4"); rd("R4"); rd("R6");
        sel(16'h0002, "R6"); rd("R6"); rd("R6");
        // R3 invalid keys
        sel(16'h0009, "R3"); rd("R3");
        sel(16'h8009, "R3"); wr(8'h55, "R3"); wr(8'h66, "R3"); rd("R3");
        sel(16'hC00A, "R3"); rd("R3");
        // R7 / R8 writable entry
        sel(16'h0003, "R7"); wr(8'h99, "R7");
        sel(16'h8003, "R7"); wr(8'h5A, "R7"); wr(8'hA5, "R8");
        wr(8'h01, "R8"); wr(8'h02, "R8");
        sel(16'h0003, "R7"); rd("R7"); rd("R7"); rd("R6");
        sel(16'h8000, "R7"); wr(8'hEE, "R7");
        sel(16'h0000, "R7"); rd("R7");
        // writable local entry
        pll(1, 7, 1);
        sel(16'hC007, "R8"); wr(8'h77, "R8"); wr(8'h78, "R8");
        sel(16'h4007, "R8"); rd("R8");
        // R9 precedence
        sel(16'h0000, "R9"); rd("R9");
        sel_wr = 1; sel_key = 16'h4002; data_rd = 1; tick("R9");
        rd("R9");
        sel_wr = 1; sel_key = 16'h0000; data_wr = 1; data_wdata = 8'h12; tick("R9");
        sel(16'h8003, "R9");
        data_wr = 1; data_rd = 1; data_wdata = 8'h3C; tick("R9");
        data_wr = 1; data_wdata = 8'h3D; tick("R9");
        sel(16'h0003, "R9"); rd("R9"); rd("R9");
        // R10 preload ignored while bus busy, clamp to DEPTH
        data_rd = 1; pl_len_we = 1; pl_bank = 0; pl_index = 3'd3; pl_len = 16'd1; tick("R10");
        sel_wr = 1; sel_key = 16'h0003; pl_byte_we = 1; pl_bank = 0; pl_index = 3'd3;
        pl_offset = 4'd0; pl_byte = 8'hF0; tick("R10");
        rd("R10"); rd("R10"); rd("R10");
        sel(16'h4005, "R10");
        for (int o = 0; o < 18; o++) rd("R10");

        $display("%0d/%0d checks passed", checks - fails, checks);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule